// File: doc/BRIEF.md
# Host Serial Link with Address Marker

This block connects a network controller to a host processor over a serial link. It has one line into the block (`ser_rxd`) and one line out of it (`ser_txd`). Every character is sent least significant bit first. Four framings are chosen by two configuration inputs. In the clocked modes, the host supplies the bit clock and a frame-active strobe, and a character is 8 data bits, optionally followed by one address/data marker bit. In the asynchronous modes, a character is a low start bit, then 8 data bits, then the optional marker, then an optional parity bit, then a high stop bit. The marker tells the far side whether a byte is an address (1) or data (0).

On the parallel side, the block offers one byte-plus-marker stream in each direction, each with a valid/ready handshake. Received characters carry one-cycle pulses that flag parity and framing errors. In the asynchronous modes, the bit timing comes from a divisor input. The divisor sets a tick, and sixteen ticks make one bit. Parity can be even or odd. It covers the data and the marker, and it exists only in the asynchronous framings.

Top module: `host_serial_link`

## Requirements
- R1: Data goes out and comes in least significant bit first in every mode: the first bit after the start bit (asynchronous), or the first bit of a clocked character, is data bit 0.
- R2: An asynchronous character is: start bit at 0, 8 data bits, the marker when enabled, parity when enabled, then a stop bit at 1. Each bit lasts 16 ticks, and one tick is `baud_div` clock cycles (`baud_div` of 0 or 1 gives a tick every cycle).
- R3: With `cfg_marker_en`=1, the marker bit follows data bit 7 and comes before any parity bit, in both asynchronous and clocked modes. 1 means address and 0 means data. With `cfg_marker_en`=0, no marker bit is sent, `tx_marker` is ignored, and `rx_marker` reads 0.
- R4: With `cfg_parity_en`=1 in an asynchronous mode, the parity bit makes the count of ones over data, marker and parity even (`cfg_parity_odd`=0) or odd (`cfg_parity_odd`=1). In the clocked modes, `cfg_parity_en` has no effect.
- R5: A received character whose parity bit is wrong is still delivered. `rx_par_err` is high for exactly the one cycle in which that character's `rx_valid` rises.
- R6: If the receiver samples the stop bit low, it delivers the character with a one-cycle `rx_frm_err` pulse. It then ignores the line until the line has gone high.
- R7: The receiver checks the start bit again at mid-bit (8 ticks after the falling edge). A low pulse shorter than that yields no character.
- R8: In a clocked mode, the receiver samples `ser_rxd` on each rising edge of `host_sclk` while `host_frame_n` is low. The transmitter shows bit 0 on `ser_txd` as soon as a character is accepted, and moves to the next bit on each falling edge of `host_sclk` while `host_frame_n` is low. While `host_frame_n` is high, the receive bit count returns to zero.
- R9: A transmit character is taken when `tx_valid` and `tx_ready` are both high. `tx_ready` then stays low until the last bit has finished (the stop bit in the asynchronous modes). `rx_valid`, `rx_data` and `rx_marker` hold until `rx_ready` is high. A new character overwrites one that has not been taken.
- R10: During reset, `tx_ready`=1, `ser_txd`=1, `rx_valid`=0, and both error pulses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_async | input | 1 | 1: asynchronous framing, 0: host-clocked framing |
| cfg_marker_en | input | 1 | Adds the address/data marker bit |
| cfg_parity_en | input | 1 | Adds parity (asynchronous modes only) |
| cfg_parity_odd | input | 1 | 1: odd parity, 0: even parity |
| baud_div | input | DIV_W | Clock cycles per oversampling tick |
| host_sclk | input | 1 | Host bit clock (clocked modes, idles low) |
| host_frame_n | input | 1 | Low while the host is clocking characters |
| ser_rxd | input | 1 | Serial data into the block |
| ser_txd | output | 1 | Serial data out of the block, idles high |
| tx_valid | input | 1 | Transmit character offered |
| tx_ready | output | 1 | Transmitter idle, can accept a character |
| tx_data | input | DATA_W | Transmit byte |
| tx_marker | input | 1 | Transmit marker (1 address, 0 data) |
| rx_valid | output | 1 | Received character available |
| rx_ready | input | 1 | Consumer takes the received character |
| rx_data | output | DATA_W | Received byte |
| rx_marker | output | 1 | Received marker |
| rx_par_err | output | 1 | One-cycle pulse: parity mismatch on delivered character |
| rx_frm_err | output | 1 | One-cycle pulse: stop bit was low |

## Verification
The bench targets the points where the frame length changes: marker on or off, parity on or off, and parity enabled in a clocked mode. A design that placed the marker after the parity bit, or that counted parity in clocked mode, would misalign every later bit or lose the last one. A wrong parity bit and a stop bit held low are injected. A block that dropped such characters, or that took the stuck-low line as a new start bit, would give a missing or extra character. Other cases include a short low glitch, which a receiver without the mid-bit recheck would turn into a spurious byte; an abandoned partial clocked frame, which would shift the next character if the bit count were not reset; and a held receive output with `rx_ready` low, which must not change or vanish.

// File: rtl/hsl_pkg.sv
package hsl_pkg;

  typedef struct packed {
    logic async_m;   // asynchronous framing
    logic mark_en;   // address/data marker present
    logic par_en;    // parity requested
    logic par_odd;   // odd parity when set
  } hsl_cfg_t;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_BITS,
    RX_STOP,
    RX_WAITHI
  } rx_st_e;

  // bits between start and stop (async) or per character (clocked)
  function automatic int payload_bits(input int dw, input hsl_cfg_t c);
    return dw + int'(c.mark_en) + int'(c.async_m & c.par_en);
  endfunction

endpackage

// File: rtl/hsl_sync.sv
module hsl_sync #(
  parameter int W = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/hsl_baud.sv
module hsl_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             wrap;

  assign wrap = (div <= DIV_W'(1)) || (cnt_q >= div - DIV_W'(1));
  assign tick = en & wrap;

  always_comb begin
    if (!en || wrap) cnt_d = '0;
    else             cnt_d = cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && en && div >= DIV_W'(2)) |=> !tick);
endmodule

// File: rtl/hsl_rx.sv
module hsl_rx import hsl_pkg::*; #(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  hsl_cfg_t          cfg,
  input  logic              tick,
  input  logic              rxd,
  input  logic              sclk_rise,
  input  logic              frame_act,
  input  logic              rx_ready,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_marker,
  output logic              rx_par_err,
  output logic              rx_frm_err
);
  localparam int SR_W  = DATA_W + 2;
  localparam int IDX_W = $clog2(SR_W);
  localparam int OV_W  = $clog2(OVS);
  localparam logic [OV_W-1:0] OV_LAST = OV_W'(OVS - 1);
  localparam logic [OV_W-1:0] OV_MID  = OV_W'(OVS / 2 - 1);

  rx_st_e             st_q, st_d;
  logic [OV_W-1:0]    ov_q, ov_d;
  logic [IDX_W-1:0]   idx_q, idx_d, last_idx;
  logic [SR_W-1:0]    sh_q, sh_d;
  logic               vld_q, vld_d, mk_q, mk_d, pe_q, pe_d, fe_q, fe_d;
  logic [DATA_W-1:0]  dat_q, dat_d;
  logic               deliver, stop_bad, ov_end, par_calc, par_bit;

  assign last_idx = IDX_W'(payload_bits(DATA_W, cfg) - 1);
  assign ov_end   = tick && (ov_q == OV_LAST);

  // next-state: bit framing
  always_comb begin
    st_d     = st_q;
    ov_d     = ov_q;
    idx_d    = idx_q;
    sh_d     = sh_q;
    deliver  = 1'b0;
    stop_bad = 1'b0;
    if (tick) ov_d = ov_q + OV_W'(1);
    case (st_q)
      RX_IDLE: begin
        ov_d = '0;
        if (cfg.async_m) begin
          if (!rxd) st_d = RX_START;
        end else if (!frame_act) begin
          idx_d = '0;
        end else if (sclk_rise) begin
          sh_d[idx_q] = rxd;
          if (idx_q == last_idx) begin
            idx_d   = '0;
            deliver = 1'b1;
          end else begin
            idx_d = idx_q + IDX_W'(1);
          end
        end
      end
      RX_START: if (tick && ov_q == OV_MID) begin
        ov_d  = '0;
        idx_d = '0;
        sh_d  = '0;
        st_d  = rxd ? RX_IDLE : RX_BITS;
      end
      RX_BITS: if (ov_end) begin
        ov_d        = '0;
        sh_d[idx_q] = rxd;
        if (idx_q == last_idx) st_d = RX_STOP;
        else                   idx_d = idx_q + IDX_W'(1);
      end
      RX_STOP: if (ov_end) begin
        ov_d     = '0;
        deliver  = 1'b1;
        stop_bad = !rxd;
        st_d     = rxd ? RX_IDLE : RX_WAITHI;
      end
      RX_WAITHI: if (rxd) st_d = RX_IDLE;
      default: st_d = RX_IDLE;
    endcase
    if (!cfg.async_m && st_q != RX_IDLE) begin
      st_d  = RX_IDLE;
      idx_d = '0;
    end
  end

  assign par_calc = (^sh_d[DATA_W-1:0]) ^ (cfg.mark_en & sh_d[DATA_W]) ^ cfg.par_odd;
  assign par_bit  = cfg.mark_en ? sh_d[DATA_W+1] : sh_d[DATA_W];

  // next-state: output holding register
  always_comb begin
    vld_d = vld_q;
    dat_d = dat_q;
    mk_d  = mk_q;
    pe_d  = 1'b0;
    fe_d  = 1'b0;
    if (rx_ready) vld_d = 1'b0;
    if (deliver) begin
      vld_d = 1'b1;
      dat_d = sh_d[DATA_W-1:0];
      mk_d  = cfg.mark_en & sh_d[DATA_W];
      pe_d  = cfg.async_m & cfg.par_en & (par_calc != par_bit);
      fe_d  = stop_bad;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= RX_IDLE;
      ov_q  <= '0;
      idx_q <= '0;
      sh_q  <= '0;
      vld_q <= 1'b0;
      dat_q <= '0;
      mk_q  <= 1'b0;
      pe_q  <= 1'b0;
      fe_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      ov_q  <= ov_d;
      idx_q <= idx_d;
      sh_q  <= sh_d;
      vld_q <= vld_d;
      dat_q <= dat_d;
      mk_q  <= mk_d;
      pe_q  <= pe_d;
      fe_q  <= fe_d;
    end
  end

  assign rx_valid   = vld_q;
  assign rx_data    = dat_q;
  assign rx_marker  = mk_q;
  assign rx_par_err = pe_q;
  assign rx_frm_err = fe_q;

  // R5
  par_err_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_par_err |-> rx_valid);
  // R6
  frm_err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_frm_err |=> !rx_frm_err);
  // R9
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready && !deliver) |=>
      (rx_valid && $stable(rx_data) && $stable(rx_marker)));
  // R4
  clocked_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg.async_m && !$past(cfg.async_m)) |-> (!rx_par_err && !rx_frm_err));
endmodule

// File: rtl/hsl_tx.sv
module hsl_tx import hsl_pkg::*; #(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  hsl_cfg_t          cfg,
  input  logic              tick,
  input  logic              sclk_fall,
  input  logic              frame_act,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_marker,
  output logic              tx_ready,
  output logic              txd
);
  localparam int SR_W  = DATA_W + 2;
  localparam int FR_W  = SR_W + 2;
  localparam int CNT_W = $clog2(FR_W + 1);
  localparam int OV_W  = $clog2(OVS);
  localparam logic [OV_W-1:0] OV_LAST = OV_W'(OVS - 1);

  logic              busy_q, busy_d;
  logic [FR_W-1:0]   sh_q, sh_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d, nsend;
  logic [OV_W-1:0]   ov_q, ov_d;
  logic [SR_W-1:0]   pay;
  logic              par, accept, step;

  // payload: data, then marker, then parity; unused upper bits idle high
  always_comb begin
    par = (^tx_data) ^ (cfg.mark_en & tx_marker) ^ cfg.par_odd;
    pay = '1;
    pay[DATA_W-1:0] = tx_data;
    if (cfg.mark_en) begin
      pay[DATA_W] = tx_marker;
      if (cfg.async_m && cfg.par_en) pay[DATA_W+1] = par;
    end else if (cfg.async_m && cfg.par_en) begin
      pay[DATA_W] = par;
    end
  end

  assign nsend  = CNT_W'(payload_bits(DATA_W, cfg) + (cfg.async_m ? 2 : 0));
  assign accept = tx_valid && !busy_q;
  assign step   = busy_q && (cfg.async_m ? (tick && ov_q == OV_LAST)
                                         : (sclk_fall && frame_act));

  always_comb begin
    busy_d = busy_q;
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    ov_d   = ov_q;
    if (busy_q && tick) ov_d = (ov_q == OV_LAST) ? '0 : ov_q + OV_W'(1);
    if (accept) begin
      busy_d = 1'b1;
      ov_d   = '0;
      cnt_d  = nsend;
      sh_d   = cfg.async_m ? {1'b1, pay, 1'b0} : {2'b11, pay};
    end else if (step) begin
      sh_d  = {1'b1, sh_q[FR_W-1:1]};
      cnt_d = cnt_q - CNT_W'(1);
      if (cnt_q == CNT_W'(1)) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sh_q   <= '1;
      cnt_q  <= '0;
      ov_q   <= '0;
    end else begin
      busy_q <= busy_d;
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      ov_q   <= ov_d;
    end
  end

  assign tx_ready = !busy_q;
  assign txd      = sh_q[0];

  // R9
  tx_accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);
  // R10
  tx_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> txd);
  // R2
  tx_start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && cfg.async_m) |=> !txd);
  // R2
  tx_stop_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tx_ready) && cfg.async_m) |-> $past(txd));
endmodule

// File: rtl/host_serial_link.sv
module host_serial_link import hsl_pkg::*; #(
  parameter int DATA_W = 8,
  parameter int OVS    = 16,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_async,
  input  logic              cfg_marker_en,
  input  logic              cfg_parity_en,
  input  logic              cfg_parity_odd,
  input  logic [DIV_W-1:0]  baud_div,
  input  logic              host_sclk,
  input  logic              host_frame_n,
  input  logic              ser_rxd,
  output logic              ser_txd,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_marker,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_marker,
  output logic              rx_par_err,
  output logic              rx_frm_err
);
  hsl_cfg_t cfg;
  logic     rst_s1_q, rst_n_i;
  logic     rxd_s, sclk_s, frame_n_s, sclk_prev_q;
  logic     sclk_rise, sclk_fall, frame_act, tick;

  assign cfg.async_m = cfg_async;
  assign cfg.mark_en = cfg_marker_en;
  assign cfg.par_en  = cfg_parity_en;
  assign cfg.par_odd = cfg_parity_odd;

  // reset asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_n_i  <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_n_i  <= rst_s1_q;
    end
  end

  hsl_sync #(.W(3), .RST_VAL(3'b101)) u_in_sync (
    .clk   (clk),
    .rst_n (rst_n_i),
    .d     ({ser_rxd, host_sclk, host_frame_n}),
    .q     ({rxd_s, sclk_s, frame_n_s})
  );

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sclk_prev_q <= 1'b0;
    else          sclk_prev_q <= sclk_s;
  end

  assign sclk_rise = sclk_s & ~sclk_prev_q;
  assign sclk_fall = ~sclk_s & sclk_prev_q;
  assign frame_act = ~frame_n_s;

  hsl_baud #(.DIV_W(DIV_W)) u_baud (
    .clk   (clk),
    .rst_n (rst_n_i),
    .en    (cfg_async),
    .div   (baud_div),
    .tick  (tick)
  );

  hsl_rx #(.DATA_W(DATA_W), .OVS(OVS)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .cfg        (cfg),
    .tick       (tick),
    .rxd        (rxd_s),
    .sclk_rise  (sclk_rise),
    .frame_act  (frame_act),
    .rx_ready   (rx_ready),
    .rx_valid   (rx_valid),
    .rx_data    (rx_data),
    .rx_marker  (rx_marker),
    .rx_par_err (rx_par_err),
    .rx_frm_err (rx_frm_err)
  );

  hsl_tx #(.DATA_W(DATA_W), .OVS(OVS)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .cfg       (cfg),
    .tick      (tick),
    .sclk_fall (sclk_fall),
    .frame_act (frame_act),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .tx_marker (tx_marker),
    .tx_ready  (tx_ready),
    .txd       (ser_txd)
  );
endmodule

// File: tb/host_serial_link_bench.sv
module host_serial_link_bench;
  localparam int BITC = 32;   // clocks per async bit with baud_div = 2
  localparam int HALF = 8;    // clocks per host clock phase

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic cfg_async = 1'b1, cfg_marker_en = 1'b0, cfg_parity_en = 1'b0, cfg_parity_odd = 1'b0;
  logic [15:0] baud_div = 16'd2;
  logic host_sclk = 1'b0, host_frame_n = 1'b1, ser_rxd = 1'b1;
  logic ser_txd, tx_ready, rx_valid, rx_marker, rx_par_err, rx_frm_err;
  logic tx_valid = 1'b0, tx_marker = 1'b0, rx_ready = 1'b1;
  logic [7:0] tx_data = 8'h00, rx_data;

  host_serial_link u_host_serial_link (
    .clk(clk), .rst_n(rst_n), .cfg_async(cfg_async), .cfg_marker_en(cfg_marker_en),
    .cfg_parity_en(cfg_parity_en), .cfg_parity_odd(cfg_parity_odd), .baud_div(baud_div),
    .host_sclk(host_sclk), .host_frame_n(host_frame_n), .ser_rxd(ser_rxd), .ser_txd(ser_txd),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_marker(tx_marker),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .rx_marker(rx_marker),
    .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err));

  int total = 0, bad = 0;
  logic [10:0] exp_q[$];   // {frm_err, par_err, marker, data}
  string       tag_q[$];
  logic pe_seen = 1'b0, fe_seen = 1'b0;

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  function automatic logic pbit(input logic [7:0] d, input logic m);
    return (^d) ^ (cfg_marker_en & m) ^ cfg_parity_odd;
  endfunction

  // reference side of the receive stream: every clock, compare deliveries with the queue
  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_par_err) pe_seen = 1'b1;
      if (rx_frm_err) fe_seen = 1'b1;
      if (rx_valid && rx_ready) begin
        if (exp_q.size() == 0) begin
          check("R7 unexpected character", 32'({rx_marker, rx_data}), 32'hdead);
        end else begin
          string t;
          t = tag_q.pop_front();
          check(t, 32'({fe_seen, pe_seen, rx_marker, rx_data}), 32'(exp_q.pop_front()));
        end
        pe_seen = 1'b0;
        fe_seen = 1'b0;
      end
    end
  end

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_cfg(input logic a, input logic m, input logic pe, input logic po);
    clks(4);
    cfg_async = a; cfg_marker_en = m; cfg_parity_en = pe; cfg_parity_odd = po;
    clks(4);
  endtask

  // drive one asynchronous character into the block
  task automatic rx_async(input logic [7:0] d, input logic m, input logic flip_par,
                          input logic stop_low, input string tag);
    logic p;
    p = pbit(d, m) ^ flip_par;
    exp_q.push_back({stop_low, flip_par & cfg_parity_en, cfg_marker_en & m, d});
    tag_q.push_back(tag);
    ser_rxd = 1'b0; clks(BITC);
    for (int i = 0; i < 8; i++) begin ser_rxd = d[i]; clks(BITC); end
    if (cfg_marker_en) begin ser_rxd = m; clks(BITC); end
    if (cfg_parity_en) begin ser_rxd = p; clks(BITC); end
    ser_rxd = !stop_low; clks(BITC);
    if (stop_low) begin clks(2 * BITC); ser_rxd = 1'b1; clks(2 * BITC); end
    else clks(BITC);
  endtask

  // send one asynchronous character and decode the line
  task automatic tx_async(input logic [7:0] d, input logic m, input string tag);
    logic [9:0] exp_b, act_b;
    int nb, w;
    exp_b = '0; act_b = '0;
    exp_b[7:0] = d; nb = 8;
    if (cfg_marker_en) begin exp_b[nb] = m; nb++; end
    if (cfg_parity_en) begin exp_b[nb] = pbit(d, m); nb++; end
    tx_data = d; tx_marker = m; tx_valid = 1'b1;
    clks(1);
    tx_valid = 1'b0;
    check("R9 tx_ready low after accept", 32'(tx_ready), 32'd0);
    w = 0;
    while (ser_txd && w < 100) begin clks(1); w++; end
    clks(BITC / 2);
    check({tag, " start bit"}, 32'(ser_txd), 32'd0);
    for (int i = 0; i < nb; i++) begin clks(BITC); act_b[i] = ser_txd; end
    check({tag, " bits"}, 32'(act_b), 32'(exp_b));
    clks(BITC);
    check("R2 stop bit high", 32'(ser_txd), 32'd1);
    w = 0;
    while (!tx_ready && w < 64) begin clks(1); w++; end
    check("R9 tx_ready back", 32'(tx_ready), 32'd1);
    clks(BITC);
  endtask

  // one host-clocked character in each direction
  task automatic sync_xfer(input logic [7:0] rd, input logic rm,
                           input logic [7:0] td, input logic tm, input string tag);
    logic [8:0] exp_b, act_b;
    int nb;
    nb = 8 + int'(cfg_marker_en);
    exp_b = {cfg_marker_en & tm, td};
    act_b = '0;
    tx_data = td; tx_marker = tm; tx_valid = 1'b1;
    clks(1);
    tx_valid = 1'b0;
    clks(4);
    exp_q.push_back({2'b00, cfg_marker_en & rm, rd});
    tag_q.push_back(tag);
    host_frame_n = 1'b0; clks(HALF);
    for (int i = 0; i < nb; i++) begin
      ser_rxd = (i < 8) ? rd[i] : rm;
      clks(HALF);
      act_b[i] = ser_txd;
      host_sclk = 1'b1; clks(HALF);
      host_sclk = 1'b0;
    end
    clks(HALF);
    host_frame_n = 1'b1; ser_rxd = 1'b1;
    clks(HALF);
    check({tag, " tx bits"}, 32'(act_b), 32'(exp_b));
    check("R9 clocked tx done", 32'(tx_ready), 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL R9 watchdog act=hung exp=finished");
    finish_run();
  end

  initial begin
    clks(5);
    // R10 reset state
    check("R10 tx_ready in reset", 32'(tx_ready), 32'd1);
    check("R10 ser_txd in reset", 32'(ser_txd), 32'd1);
    check("R10 rx_valid in reset", 32'(rx_valid), 32'd0);
    check("R10 error pulses in reset", 32'({rx_par_err, rx_frm_err}), 32'd0);
    rst_n = 1'b1;
    clks(10);

    // plain asynchronous, no marker, no parity
    set_cfg(1, 0, 0, 0);
    rx_async(8'hA5, 0, 0, 0, "R1 async plain rx A5");
    rx_async(8'h3C, 1, 0, 0, "R3 marker ignored when off rx 3C");
    tx_async(8'h81, 0, "R1 async plain tx");
    tx_async(8'h3C, 1, "R3 tx_marker ignored when off");

    // marker and even parity
    set_cfg(1, 1, 1, 0);
    rx_async(8'h47, 1, 0, 0, "R3 async address marker rx");
    rx_async(8'h10, 0, 0, 0, "R4 even parity data rx");
    tx_async(8'hB2, 1, "R4 even parity tx with marker");

    // odd parity, no marker
    set_cfg(1, 0, 1, 1);
    rx_async(8'h07, 0, 0, 0, "R4 odd parity rx");
    tx_async(8'h07, 0, "R4 odd parity tx");

    // parity error delivered with pulse
    set_cfg(1, 1, 1, 0);
    rx_async(8'h6E, 1, 1, 0, "R5 parity error delivered");

    // framing error, then a clean character
    rx_async(8'hC3, 0, 0, 1, "R6 framing error delivered");
    rx_async(8'h5A, 1, 0, 0, "R6 clean character after break");

    // short glitch rejected
    ser_rxd = 1'b0; clks(6); ser_rxd = 1'b1;
    clks(3 * BITC);
    check("R7 glitch gives no character", 32'(rx_valid), 32'd0);
    check("R7 queue drained", 32'(exp_q.size()), 32'd0);

    // held output while rx_ready is low
    rx_ready = 1'b0;
    rx_async(8'h99, 0, 0, 0, "R9 held character");
    check("R9 rx_valid held", 32'(rx_valid), 32'd1);
    clks(40);
    check("R9 rx_data stable while held", 32'({rx_valid, rx_data}), 32'h199);
    rx_ready = 1'b1;
    clks(4);
    check("R9 released after ready", 32'(rx_valid), 32'd0);

    // host-clocked modes; parity enable must not add a bit
    set_cfg(0, 0, 1, 0);
    sync_xfer(8'hD4, 0, 8'h2B, 0, "R8 clocked plain");
    set_cfg(0, 1, 1, 1);
    sync_xfer(8'h01, 1, 8'hE6, 1, "R3 clocked marker address");
    sync_xfer(8'hFE, 0, 8'h55, 0, "R4 clocked parity ignored");

    // abandoned partial frame resets the receive count
    host_frame_n = 1'b0; clks(HALF);
    for (int i = 0; i < 3; i++) begin
      ser_rxd = 1'b0; clks(HALF); host_sclk = 1'b1; clks(HALF); host_sclk = 1'b0;
    end
    clks(HALF); host_frame_n = 1'b1; ser_rxd = 1'b1; clks(4 * HALF);
    check("R8 partial frame gives no character", 32'(rx_valid), 32'd0);
    sync_xfer(8'h8C, 1, 8'h4D, 0, "R8 frame after partial");

    clks(100);
    check("R8 all characters delivered", 32'(exp_q.size()), 32'd0);
    finish_run();
  end
endmodule